// File: doc/BRIEF.md
# Pipelined Feistel Round Stage

This block computes one round of a 64-bit Feistel block cipher and accepts a new block on every clock. A block is a left and a right 32-bit half, qualified by a valid bit, and comes with its own 32-bit round subkey. The subkey is XORed into the left half. The four bytes of that keyed word address four 256-entry, 32-bit substitution tables. The round function combines the four table words as `((T1 + T2) XOR T3) + T4`, with both additions modulo 2^32. Its result is XORed into the right half. The halves are then swapped and the pair leaves the block exactly five clocks after it entered.

Both 32-bit additions are cut into a lower and an upper 16-bit part. The carry out of the lower part is registered and consumed by the upper part one stage later, so no stage holds a full 32-bit carry chain. Software or a key-schedule engine fills the tables through a plain write port. A full cipher is built by chaining one instance per round, each with its own tables and subkey.

Top module: `feistel_round_pipe`

## Requirements
- R1: `out_valid` repeats `in_valid` exactly five rising edges later, and blocks presented on consecutive cycles all emerge on consecutive cycles.
- R2: For each emerging block, `out_right` equals the block's `in_left ^ subkey`.
- R3: For each emerging block, `out_left` equals `in_right ^ F(k)` with `k = in_left ^ subkey` and `F(k) = ((T1[k[31:24]] + T2[k[23:16]]) XOR T3[k[15:8]]) + T4[k[7:0]]`.
- R4: Both additions in F are modulo 2^32: a carry out of bit 15 reaches bit 16, and a carry out of bit 31 is discarded.
- R5: When `tbl_we` is 1 at a rising edge, `tbl_wdata` is stored in entry `tbl_addr` of the table chosen by `tbl_sel` (0 = T1, 1 = T2, 2 = T3, 3 = T4). When `tbl_we` is 0, the values on `tbl_sel`, `tbl_addr` and `tbl_wdata` change no table.
- R6: A block sampled at rising edge n reads its tables at edge n+1. A write sampled at edge n+1 to an entry that block reads is not seen by it, because the block gets the old word. A block sampled at edge n+2 or later sees the new word.
- R7: While `out_valid` is 0, `out_left` and `out_right` keep the value of the last block that emerged.
- R8: While `rst_n` is 0, `out_valid` is 0 and blocks presented are dropped. Release of reset takes effect after two rising edges.
- R9: Each block uses the subkey presented with it, so blocks with different subkeys can follow one another on consecutive cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| in_valid | input | 1 | Input block qualifier |
| in_left | input | 32 | Left half of the input block |
| in_right | input | 32 | Right half of the input block |
| subkey | input | 32 | Round subkey for this block |
| tbl_we | input | 1 | Table write strobe |
| tbl_sel | input | 2 | Table select for a write (0..3 = T1..T4) |
| tbl_addr | input | 8 | Entry index for a write |
| tbl_wdata | input | 32 | Word written to the table |
| out_valid | output | 1 | Output block qualifier |
| out_left | output | 32 | New left half: old right half XOR F |
| out_right | output | 32 | New right half: keyed old left half |

## Verification
A table write and a table read by an in-flight block can fall on the same clock edge, possibly on the same entry. The bench provokes this by presenting a block and, one cycle later, writing a new word to the T1 entry that block addresses. It then presents a second block with the same keyed left half. The first block must carry F built from the old word and the second block F built from the new word. Both results are compared against a bench model whose table copy is updated at the moment the write is issued.

// File: rtl/frp_pkg.sv
package frp_pkg;
  // Word width of one half of the block.
  localparam int FRP_HALF_W  = 32;
  // Table index width: one byte of the keyed half per table.
  localparam int FRP_IDX_W   = 8;
  // Number of substitution tables the round function consumes.
  localparam int FRP_NTBL    = FRP_HALF_W / FRP_IDX_W;
  // Width of the select field on the table write port.
  localparam int FRP_SEL_W   = $clog2(FRP_NTBL);
  // Depth of the round pipeline.
  localparam int FRP_DEPTH   = 5;
endpackage

// File: rtl/frp_rst_sync.sv
module frp_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic [1:0] sync_q;
  logic [1:0] sync_d;

  always_comb begin
    sync_d = {sync_q[0], 1'b1};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync_q <= '0;
    end else begin
      sync_q <= sync_d;
    end
  end

  assign rst_sync_n = sync_q[1];
endmodule

// File: rtl/frp_table.sv
module frp_table #(
  parameter int DATA_W = 32,
  parameter int ADDR_W = 8,
  localparam int DEPTH = 1 << ADDR_W
) (
  input  logic              clk,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              rd_en,
  input  logic [ADDR_W-1:0] rd_addr,
  output logic [DATA_W-1:0] rd_data
);
  logic [DATA_W-1:0] mem [DEPTH];

  // Write and read share an edge; the read register captures the word
  // held before that edge, so a same-entry collision returns old data.
  always_ff @(posedge clk) begin
    if (wr_en) begin
      mem[wr_addr] <= wr_data;
    end
  end

  always_ff @(posedge clk) begin
    if (rd_en) begin
      rd_data <= mem[rd_addr];
    end
  end
endmodule

// File: rtl/feistel_round_pipe.sv
module feistel_round_pipe
  import frp_pkg::*;
#(
  parameter int HALF_W = FRP_HALF_W,
  parameter int IDX_W  = FRP_IDX_W,
  localparam int NTBL  = HALF_W / IDX_W,
  localparam int SEL_W = $clog2(NTBL),
  localparam int LO_W  = HALF_W / 2,
  localparam int HI_W  = HALF_W - LO_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  input  logic [HALF_W-1:0] in_left,
  input  logic [HALF_W-1:0] in_right,
  input  logic [HALF_W-1:0] subkey,
  input  logic              tbl_we,
  input  logic [SEL_W-1:0]  tbl_sel,
  input  logic [IDX_W-1:0]  tbl_addr,
  input  logic [HALF_W-1:0] tbl_wdata,
  output logic              out_valid,
  output logic [HALF_W-1:0] out_left,
  output logic [HALF_W-1:0] out_right
);
  // The round function combines exactly four table words; HALF_W / IDX_W
  // must equal 4 for the datapath below.

  logic rst_q;

  frp_rst_sync u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_q)
  );

  // ---------------------------------------------------------------------
  // Valid chain: one bit per stage
  // ---------------------------------------------------------------------
  logic [FRP_DEPTH-1:0] vld_q;
  logic [FRP_DEPTH-1:0] vld_d;

  always_comb begin
    vld_d = {vld_q[FRP_DEPTH-2:0], in_valid};
  end

  always_ff @(posedge clk or negedge rst_q) begin
    if (!rst_q) begin
      vld_q <= '0;
    end else begin
      vld_q <= vld_d;
    end
  end

  // ---------------------------------------------------------------------
  // Stage 1: subkey mix; the registered keyed half addresses the tables
  // ---------------------------------------------------------------------
  logic [HALF_W-1:0] key1_d, key1_q, rgt1_q;

  always_comb begin
    key1_d = in_left ^ subkey;
  end

  always_ff @(posedge clk) begin
    if (in_valid) begin
      key1_q <= key1_d;
      rgt1_q <= in_right;
    end
  end

  // ---------------------------------------------------------------------
  // Stage 2: synchronous table read, halves delay-matched
  // ---------------------------------------------------------------------
  logic [HALF_W-1:0] tdat [NTBL];
  logic [HALF_W-1:0] key2_q, rgt2_q;

  for (genvar t = 0; t < NTBL; t++) begin : g_tbl
    frp_table #(
      .DATA_W (HALF_W),
      .ADDR_W (IDX_W)
    ) u_tbl (
      .clk     (clk),
      .wr_en   (tbl_we && (tbl_sel == SEL_W'(t))),
      .wr_addr (tbl_addr),
      .wr_data (tbl_wdata),
      .rd_en   (vld_q[0]),
      .rd_addr (key1_q[HALF_W-1-t*IDX_W -: IDX_W]),
      .rd_data (tdat[t])
    );
  end

  always_ff @(posedge clk) begin
    if (vld_q[0]) begin
      key2_q <= key1_q;
      rgt2_q <= rgt1_q;
    end
  end

  // ---------------------------------------------------------------------
  // Stage 3: lower half of T1 + T2, carry registered
  // ---------------------------------------------------------------------
  logic [LO_W:0]     sum1lo_d;
  logic [LO_W-1:0]   sum1lo_q;
  logic              cy1_q;
  logic [HI_W-1:0]   t1hi_q, t2hi_q;
  logic [HALF_W-1:0] t3_q, t4_q, key3_q, rgt3_q;

  always_comb begin
    sum1lo_d = {1'b0, tdat[0][LO_W-1:0]} + {1'b0, tdat[1][LO_W-1:0]};
  end

  always_ff @(posedge clk) begin
    if (vld_q[1]) begin
      sum1lo_q <= sum1lo_d[LO_W-1:0];
      cy1_q    <= sum1lo_d[LO_W];
      t1hi_q   <= tdat[0][HALF_W-1:LO_W];
      t2hi_q   <= tdat[1][HALF_W-1:LO_W];
      t3_q     <= tdat[2];
      t4_q     <= tdat[3];
      key3_q   <= key2_q;
      rgt3_q   <= rgt2_q;
    end
  end

  // ---------------------------------------------------------------------
  // Stage 4: upper half of T1 + T2, XOR with T3, lower half of + T4
  // ---------------------------------------------------------------------
  logic [HI_W-1:0]   sum1hi_d;
  logic [HALF_W-1:0] mix_d;
  logic [LO_W:0]     sum2lo_d;
  logic [HI_W-1:0]   mixhi_q, t4hi_q;
  logic [LO_W-1:0]   sum2lo_q;
  logic              cy2_q;
  logic [HALF_W-1:0] key4_q, rgt4_q;

  always_comb begin
    sum1hi_d = t1hi_q + t2hi_q + HI_W'(cy1_q);
    mix_d    = {sum1hi_d, sum1lo_q} ^ t3_q;
    sum2lo_d = {1'b0, mix_d[LO_W-1:0]} + {1'b0, t4_q[LO_W-1:0]};
  end

  always_ff @(posedge clk) begin
    if (vld_q[2]) begin
      mixhi_q  <= mix_d[HALF_W-1:LO_W];
      t4hi_q   <= t4_q[HALF_W-1:LO_W];
      sum2lo_q <= sum2lo_d[LO_W-1:0];
      cy2_q    <= sum2lo_d[LO_W];
      key4_q   <= key3_q;
      rgt4_q   <= rgt3_q;
    end
  end

  // ---------------------------------------------------------------------
  // Stage 5: upper half of + T4, XOR into right half, swap
  // ---------------------------------------------------------------------
  logic [HI_W-1:0]   sum2hi_d;
  logic [HALF_W-1:0] fval_d;
  logic [HALF_W-1:0] outl_d, outr_d;
  logic [HALF_W-1:0] outl_q, outr_q;

  always_comb begin
    sum2hi_d = mixhi_q + t4hi_q + HI_W'(cy2_q);
    fval_d   = {sum2hi_d, sum2lo_q};
    outl_d   = rgt4_q ^ fval_d;
    outr_d   = key4_q;
  end

  always_ff @(posedge clk) begin
    if (vld_q[3]) begin
      outl_q <= outl_d;
      outr_q <= outr_d;
    end
  end

  assign out_valid = vld_q[FRP_DEPTH-1];
  assign out_left  = outl_q;
  assign out_right = outr_q;
endmodule

// File: rtl/frp_checker.sv
module frp_checker #(
  parameter int HALF_W = 32
) (
  input logic              clk,
  input logic              rst_q,
  input logic              in_valid,
  input logic [HALF_W-1:0] in_left,
  input logic [HALF_W-1:0] in_right,
  input logic [HALF_W-1:0] subkey,
  input logic              tbl_we,
  input logic              out_valid,
  input logic [HALF_W-1:0] out_left,
  input logic [HALF_W-1:0] out_right
);
  // Cycles since the internal reset released, saturating.
  logic [2:0] warm_q;
  // Cycles since the last table write, saturating.
  logic [3:0] quiet_q;

  always_ff @(posedge clk or negedge rst_q) begin
    if (!rst_q) begin
      warm_q  <= '0;
      quiet_q <= '0;
    end else begin
      if (warm_q != 3'd7) warm_q <= warm_q + 3'd1;
      if (tbl_we) quiet_q <= '0;
      else if (quiet_q != 4'd15) quiet_q <= quiet_q + 4'd1;
    end
  end

  logic warm;
  assign warm = (warm_q == 3'd7);

  assert_latency_R1: assert property (@(posedge clk) disable iff (!rst_q)
    warm |-> (out_valid == $past(in_valid, 5)));

  assert_swap_R2: assert property (@(posedge clk) disable iff (!rst_q)
    (warm && out_valid) |-> (out_right == $past(in_left ^ subkey, 5)));

  assert_hold_R7: assert property (@(posedge clk) disable iff (!rst_q)
    (warm && !out_valid) |-> ($stable(out_left) && $stable(out_right)));

  // R3: with tables untouched, equal keyed halves give equal F values.
  assert_keyed_only_R3: assert property (@(posedge clk) disable iff (!rst_q)
    (warm && quiet_q >= 4'd8 && out_valid && $past(out_valid) &&
     ($past(in_left ^ subkey, 5) == $past(in_left ^ subkey, 6)))
    |-> ((out_left ^ $past(in_right, 5)) == ($past(out_left) ^ $past(in_right, 6))));
endmodule

bind feistel_round_pipe frp_checker #(.HALF_W(HALF_W)) u_chk (
  .clk       (clk),
  .rst_q     (rst_q),
  .in_valid  (in_valid),
  .in_left   (in_left),
  .in_right  (in_right),
  .subkey    (subkey),
  .tbl_we    (tbl_we),
  .out_valid (out_valid),
  .out_left  (out_left),
  .out_right (out_right)
);

// File: tb/sim_feistel_round_pipe.sv
`timescale 1ns/1ps
module sim_feistel_round_pipe;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        in_valid;
  logic [31:0] in_left, in_right, subkey;
  logic        tbl_we;
  logic [1:0]  tbl_sel;
  logic [7:0]  tbl_addr;
  logic [31:0] tbl_wdata;
  logic        out_valid;
  logic [31:0] out_left, out_right;

  always #2 clk = ~clk;

  feistel_round_pipe u0 (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_left(in_left),
    .in_right(in_right), .subkey(subkey), .tbl_we(tbl_we), .tbl_sel(tbl_sel),
    .tbl_addr(tbl_addr), .tbl_wdata(tbl_wdata), .out_valid(out_valid),
    .out_left(out_left), .out_right(out_right)
  );

  int checks = 0;
  int fails  = 0;
  int cyc    = 0;
  bit done   = 0;

  always @(posedge clk) cyc <= cyc + 1;

  // Bench copy of the four tables
  logic [31:0] mt [4][256];

  function automatic logic [31:0] mf(input logic [31:0] x);
    return ((mt[0][x[31:24]] + mt[1][x[23:16]]) ^ mt[2][x[15:8]]) + mt[3][x[7:0]];
  endfunction

  function automatic logic [31:0] fill(input int s, input int i);
    logic [31:0] a;
    a = 32'(i) * 32'h0100_0193;
    return a ^ (32'(s) * 32'h9E37_79B9) ^ {8'(i), ~8'(i), 8'(s), 8'(i * 3)};
  endfunction

  // Expected-result queue
  logic [31:0] exp_l [64];
  logic [31:0] exp_r [64];
  int          exp_c [64];
  string       exp_t [64];
  int wr = 0;
  int rd = 0;
  logic [31:0] last_l, last_r;

  task automatic check(input bit ok, input string tag, input logic [31:0] act,
                       input logic [31:0] expv);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, expv);
    end
  endtask

  // Output collector, sampling at the falling edge
  always @(negedge clk) begin
    if (!done && out_valid) begin
      if (rd == wr) begin
        check(1'b0, "R8 unexpected output block", 32'd1, 32'd0);
      end else begin
        check((cyc - exp_c[rd]) == 5, "R1 latency", 32'(cyc - exp_c[rd]), 32'd5);
        check(out_right == exp_r[rd], {"R2 right half ", exp_t[rd]}, out_right, exp_r[rd]);
        check(out_left == exp_l[rd], {exp_t[rd], " left half"}, out_left, exp_l[rd]);
        last_l = out_left;
        last_r = out_right;
        rd++;
      end
    end
  end

  task automatic drive_block(input logic [31:0] l, input logic [31:0] r,
                             input logic [31:0] k, input string tag);
    logic [31:0] kl;
    kl = l ^ k;
    in_valid = 1'b1; in_left = l; in_right = r; subkey = k;
    exp_l[wr] = r ^ mf(kl);
    exp_r[wr] = kl;
    exp_c[wr] = cyc;
    exp_t[wr] = tag;
    wr++;
    @(negedge clk);
    in_valid = 1'b0;
  endtask

  task automatic write_tbl(input int s, input int a, input logic [31:0] d);
    tbl_we = 1'b1; tbl_sel = 2'(s); tbl_addr = 8'(a); tbl_wdata = d;
    mt[s][a] = d;
    @(negedge clk);
    tbl_we = 1'b0;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic drain();
    for (int i = 0; i < 20 && rd != wr; i++) @(negedge clk);
    check(rd == wr, "R1 all blocks emerged", 32'(rd), 32'(wr));
  endtask

  // {left, right, subkey}; keys differ from block to block (R9)
  localparam logic [95:0] VECS [8] = '{
    96'h0000_0000_0000_0000_0000_0000,
    96'hFFFF_FFFF_FFFF_FFFF_FFFF_FFFF,
    96'h0123_4567_89AB_CDEF_0F1E_2D3C,
    96'hDEAD_BEEF_CAFE_F00D_1234_5678,
    96'h8000_0001_7FFF_FFFE_8000_0000,
    96'h5A5A_5A5A_A5A5_A5A5_FFFF_0000,
    96'h1357_9BDF_2468_ACE0_0000_FFFF,
    96'hC3C3_3C3C_0F0F_F0F0_AAAA_5555
  };

  initial begin
    #(4 * 150000);
    if (!done) begin
      fails++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; in_valid = 1'b0; in_left = '0; in_right = '0; subkey = '0;
    tbl_we = 1'b0; tbl_sel = '0; tbl_addr = '0; tbl_wdata = '0;

    // R8: blocks presented during reset are dropped
    @(negedge clk);
    for (int i = 0; i < 6; i++) begin
      in_valid = 1'b1; in_left = 32'(i) * 32'h1111_1111; in_right = ~in_left;
      @(negedge clk);
      check(out_valid == 1'b0, "R8 out_valid low in reset", 32'(out_valid), 32'd0);
    end
    in_valid = 1'b0;
    rst_n = 1'b1;
    idle(10);
    check(rd == 0 && wr == 0, "R8 no block from reset period", 32'(rd), 32'd0);

    // R5: fill all tables
    for (int s = 0; s < 4; s++)
      for (int a = 0; a < 256; a++)
        write_tbl(s, a, fill(s, a));

    // Vector walk, back to back (R1, R2, R3, R9)
    for (int i = 0; i < 8; i++)
      drive_block(VECS[i][95:64], VECS[i][63:32], VECS[i][31:0], "R3/R9 vector");
    // Gapped pattern
    drive_block(32'h2222_0000, 32'h0000_3333, 32'h0101_0101, "R3 gapped");
    idle(2);
    drive_block(32'h7654_3210, 32'hFEDC_BA98, 32'h0, "R3 gapped");
    drain();

    // R4: carries across bit 15 and out of bit 31; F becomes 0
    write_tbl(0, 8'h11, 32'h0000_FFFF);
    write_tbl(1, 8'h22, 32'h0000_0001);
    write_tbl(2, 8'h33, 32'h0000_FFFF);
    write_tbl(3, 8'h44, 32'hFFFE_0001);
    drive_block(32'h1122_3344, 32'hA5A5_A5A5, 32'h0, "R4 carry chain");
    write_tbl(0, 8'h99, 32'hFFFF_8000);
    write_tbl(1, 8'h88, 32'h0000_8000);
    drive_block(32'h9988_7766 ^ 32'h0F0F_0F0F, 32'h1234_5678, 32'h0F0F_0F0F, "R4 wrap");
    drain();
    check(exp_l[wr-2] == 32'hA5A5_A5A5, "R4 model F zero", exp_l[wr-2], 32'hA5A5_A5A5);

    // R6: write collides with a block's table read on the same edge
    drive_block(32'h4D00_0000, 32'h0, 32'h0, "R6 old word");
    write_tbl(0, 8'h4D, 32'h1357_2468);
    drive_block(32'h4D00_0000, 32'h0, 32'h0, "R6 new word");
    drain();

    // R5: table port activity without tbl_we changes nothing
    tbl_we = 1'b0; tbl_sel = 2'd1; tbl_addr = 8'h00; tbl_wdata = 32'hBAD0_BAD0;
    @(negedge clk);
    drive_block(32'h4D00_0000, 32'h5555_AAAA, 32'h0, "R5 no write without strobe");
    drain();

    // R7: outputs hold while out_valid is low
    for (int i = 0; i < 4; i++) begin
      @(negedge clk);
      check(out_left == last_l && out_right == last_r, "R7 hold left", out_left, last_l);
      check(out_valid == 1'b0, "R7 idle out_valid", 32'(out_valid), 32'd0);
    end

    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end
endmodule